// File: doc/BRIEF.md
# Keyed Reset Controller

This block sequences the resets of a processor subsystem. Software asks for resets by writing a command word. That word must carry a fixed password byte. Any write with a wrong password is thrown away whole. The block also starts resets by itself in three cases:

- a falling edge on the external reset pin, when that source is enabled;
- a brown-out falling edge;
- a watchdog fault.

Every reset runs for a programmable number of slow-clock ticks, and the length is always a power of two. The block keeps a record of what caused the last processor reset.

The bus has three word registers, all with 32-bit data:

- **Command** at offset 0x0. Reads return 0.
- **Status** at offset 0x4. It holds two sticky event flags, the last reset cause, the synchronized pin level and a busy bit.
- **Mode** at offset 0x8. It holds the user-reset enable, two interrupt enables and the pulse length exponent.

The bus decodes `bus_addr >> 2`. Bits 1:0 of the address are ignored.

The external pin appears at the ports as two signals. `pin_sense` is the level seen on the pin. `pin_pull_low` is the enable that pulls the pin low. The slow clock arrives as a one-cycle tick in the system clock domain.

The sequencer is a state machine with three states:

| State | Meaning |
|---|---|
| IDLE | Waits for a request. |
| PULSE | Holds the selected reset outputs asserted while the tick counter runs. |
| FINISH | A one-cycle state that commits the reset cause. |

It has three transitions:

| Transition | From → To | When |
|---|---|---|
| START | IDLE → PULSE | A request is present. Clears the tick counter. |
| EXPIRE | PULSE → FINISH | The last tick of the programmed length arrives. |
| RETIRE | FINISH → IDLE | Always, after one cycle. |

Top module: `rstctl_top`

## Requirements
- R1: A write to the command register (0x0) or the mode register (0x8) takes effect only when bits 31:24 equal 0xA5. With any other value the whole write is discarded, including its low bits.
- R2: In an accepted command write, bits 0 to 3 select the resets to assert:
  - bit 0: `core_rst`;
  - bit 1: `dbg_rst`;
  - bit 2: `periph_rst`;
  - bit 3: `pin_pull_low`.

  Bits written as 0 do nothing. A command with all four bits at 0 starts nothing. No reset output is asserted outside state PULSE.
- R3: Two status flags are sticky. Bit 0 sets on a falling edge of the synchronized pin, after two synchronizer flops. Bit 1 sets in the same way on a falling edge of `brown_ok`. A status read returns the flags and then clears them. An edge that arrives in the same cycle as the read wins over the clear.
- R4: The status word (0x4) has these fields:
  - bits 1:0: the two flags;
  - bits 10:8: the reset cause;
  - bit 16: the synchronized pin level;
  - bit 17: busy.

  All other bits read 0. A read returns its data in `bus_rdata` on the clock edge that samples `bus_rd`.
- R5: Status bit 17 is 1 from START until the cycle after RETIRE. A command written while it is 1 is dropped. It is not queued.
- R6: The reset pulse lasts 2^(E+1) slow ticks, where E is mode bits 11:8. The outputs drop on the clock edge that samples the last tick.
- R7: `irq` = (status bit 0 AND mode bit 4) OR (status bit 1 AND mode bit 16).
- R8: The reset cause (status bits 10:8) has these codes:

  | Code | Cause |
  |---|---|
  | 000 | power-up |
  | 010 | watchdog |
  | 011 | software |
  | 100 | user pin |
  | 101 | brown-out |

  The cause is 000 after `rst_n`. It changes only in FINISH. A software command changes it only when that command included bit 0.
- R9: If mode bit 0 is 1 and the block is in IDLE, a pin falling edge starts a user reset. The reset asserts `core_rst` and `periph_rst` and sets the cause to 100. If mode bit 0 is 0, a pin falling edge starts no reset.
- R10: A brown-out falling edge starts a reset of the core and the peripherals with cause 101. A `wdt_fault` pulse does the same with cause 010. When several requests arrive in the same IDLE cycle, the priority is brown-out, then watchdog, then user pin, then software. The requests that lose are dropped.
- R11: Reading the mode register returns the stored fields at their write positions: bit 0, bit 4, bits 11:8 and bit 16. Mode is all zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low |
| slow_tick | input | 1 | One-cycle enable at the slow clock rate |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_sense | input | 1 | Level seen on the external reset pin |
| wdt_fault | input | 1 | Watchdog reset request pulse |
| brown_ok | input | 1 | Supply-good level; a falling edge means brown-out |
| core_rst | output | 1 | Processor core reset |
| dbg_rst | output | 1 | Debug interface reset |
| periph_rst | output | 1 | Peripheral reset |
| pin_pull_low | output | 1 | Pull the external reset pin low |
| irq | output | 1 | Combined interrupt |

## Verification
Each kind of internal fault shows at the ports within a predictable time:

- **Wrong sequencer state.** The reset outputs stay high past the 2^(E+1)-th tick, or fall before it, on that same clock edge. The busy bit misreports on the next status read.
- **Wrong cause latched.** The wrong code appears in status bits 10:8 at the first read after RETIRE.
- **Lost or stuck flag.** `irq` goes wrong on the cycle after the edge, as seen through the enables. A flag that fails to clear shows a second time on the next read.
- **Key check too lenient.** A wrong-key write becomes visible on the mode readback, or as a reset output that rises on the next cycle.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int          DATA_W  = 32;
    localparam int          KEY_LSB = 24;
    localparam logic [7:0]  WR_KEY  = 8'hA5;

    typedef enum logic [2:0] {
        CAUSE_POWER = 3'b000,
        CAUSE_WDOG  = 3'b010,
        CAUSE_SOFT  = 3'b011,
        CAUSE_USER  = 3'b100,
        CAUSE_BROWN = 3'b101
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PULSE,
        ST_FINISH
    } seq_e;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_MODE = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [3:0] erstl;
        logic       bie;
        logic       uie;
        logic       ursten;
    } mode_t;

    typedef struct packed {
        logic ext;
        logic periph;
        logic dbg;
        logic core;
    } rst_sel_t;

endpackage

// File: rtl/rstctl_sync_edge.sv
module rstctl_sync_edge #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RESET_VAL;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= RESET_VAL;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RESET_VAL;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign fall  = prev_q & ~chain_q[STAGES-1];

    // R3: a falling edge is reported for one cycle only
    p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/rstctl_pulse_timer.sv
module rstctl_pulse_timer #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    input  logic [EXP_W-1:0] erstl,
    output logic             expire
);
    localparam int MAX_SHIFT = 1 << EXP_W;
    localparam int CNT_W     = MAX_SHIFT + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] last;
    logic [EXP_W:0]   shamt;

    assign shamt  = {1'b0, erstl} + {{EXP_W{1'b0}}, 1'b1};
    assign len    = {{(CNT_W-1){1'b0}}, 1'b1} << shamt;
    assign last   = len - {{(CNT_W-1){1'b0}}, 1'b1};
    assign expire = run & tick & (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (clear)       cnt_q <= '0;
        else if (run && tick) cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end

    // R6: the count never passes the programmed length while running
    p_count_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < len));

endmodule

// File: rtl/rstctl_regs.sv
module rstctl_regs
    import rstctl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              user_fall,
    input  logic              brown_fall,
    input  logic              pin_level,
    input  logic              busy,
    input  cause_e            rst_type,
    output logic [DATA_W-1:0] bus_rdata,
    output mode_t             mode_q,
    output logic              ctrl_go,
    output rst_sel_t          ctrl_bits,
    output logic              irq
);
    reg_sel_e          sel;
    logic [ADDR_W-1:0] word_idx;
    logic              key_ok;
    logic              uflag_q;
    logic              bflag_q;
    logic              stat_rd;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] mode_word;
    logic              unused_wdata;

    assign word_idx = bus_addr >> 2;
    assign key_ok   = (bus_wdata[DATA_W-1:KEY_LSB] == WR_KEY);
    assign unused_wdata = ^{bus_wdata[23:17], bus_wdata[15:12], bus_wdata[7:5]};

    always_comb begin
        if (word_idx == ADDR_W'(0))      sel = REG_CTRL;
        else if (word_idx == ADDR_W'(1)) sel = REG_STAT;
        else if (word_idx == ADDR_W'(2)) sel = REG_MODE;
        else                             sel = REG_NONE;
    end

    assign ctrl_bits = rst_sel_t'(bus_wdata[3:0]);
    assign ctrl_go   = bus_wr & (sel == REG_CTRL) & key_ok & (|bus_wdata[3:0]);
    assign stat_rd   = bus_rd & (sel == REG_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (bus_wr && sel == REG_MODE && key_ok) begin
            mode_q.ursten <= bus_wdata[0];
            mode_q.uie    <= bus_wdata[4];
            mode_q.erstl  <= bus_wdata[11:8];
            mode_q.bie    <= bus_wdata[16];
        end
    end

    // A new edge wins over the clear of the same read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uflag_q <= 1'b0;
            bflag_q <= 1'b0;
        end else begin
            uflag_q <= (uflag_q & ~stat_rd) | user_fall;
            bflag_q <= (bflag_q & ~stat_rd) | brown_fall;
        end
    end

    assign stat_word = {14'b0, busy, pin_level, 5'b0, rst_type, 6'b0, bflag_q, uflag_q};
    assign mode_word = {15'b0, mode_q.bie, 4'b0, mode_q.erstl, 3'b0, mode_q.uie,
                        3'b0, mode_q.ursten};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (sel)
                REG_STAT: bus_rdata <= stat_word;
                REG_MODE: bus_rdata <= mode_word;
                default:  bus_rdata <= '0;
            endcase
        end
    end

    assign irq = (uflag_q & mode_q.uie) | (bflag_q & mode_q.bie);

    // R1: a write with the wrong password leaves mode untouched
    p_bad_key_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == REG_MODE && !key_ok) |=> $stable(mode_q));

    // R3: a status read clears the user flag unless a new edge arrives
    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !user_fall) |=> !uflag_q);

    // R3: an edge always leaves its flag set
    p_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        brown_fall |=> bflag_q);

endmodule

// File: rtl/rstctl_seq_fsm.sv
module rstctl_seq_fsm
    import rstctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sw_go,
    input  rst_sel_t sw_bits,
    input  logic     user_go,
    input  logic     brown_go,
    input  logic     wdog_go,
    input  logic     expire,
    output logic     busy,
    output logic     start,
    output logic     active,
    output rst_sel_t sel_q,
    output cause_e   cause_q
);
    seq_e     state_q, state_d;
    cause_e   pend_q;
    logic     upd_q;
    logic     any_go;
    rst_sel_t hw_sel;

    assign any_go = brown_go | wdog_go | user_go | sw_go;
    assign hw_sel = '{ext: 1'b0, periph: 1'b1, dbg: 1'b0, core: 1'b1};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: START, EXPIRE, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (any_go) state_d = ST_PULSE;
            ST_PULSE:  if (expire) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        active = (state_q == ST_PULSE);
        start  = (state_q == ST_IDLE) && any_go;
    end

    // Request capture at START, cause commit at RETIRE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            pend_q  <= CAUSE_POWER;
            upd_q   <= 1'b0;
            cause_q <= CAUSE_POWER;
        end else begin
            if (start) begin
                if (brown_go) begin
                    sel_q  <= hw_sel;
                    pend_q <= CAUSE_BROWN;
                    upd_q  <= 1'b1;
                end else if (wdog_go) begin
                    sel_q  <= hw_sel;
                    pend_q <= CAUSE_WDOG;
                    upd_q  <= 1'b1;
                end else if (user_go) begin
                    sel_q  <= hw_sel;
                    pend_q <= CAUSE_USER;
                    upd_q  <= 1'b1;
                end else begin
                    sel_q  <= sw_bits;
                    pend_q <= CAUSE_SOFT;
                    upd_q  <= sw_bits.core;
                end
            end
            if (state_q == ST_FINISH && upd_q) cause_q <= pend_q;
        end
    end

    // R5: FINISH always returns to IDLE
    p_finish_returns_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |=> (state_q == ST_IDLE));

    // R5: a request while busy does not alter the running selection
    p_busy_holds_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && sw_go) |=> $stable(sel_q));

    // R8: the cause only moves on leaving FINISH
    p_cause_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_FINISH) |=> $stable(cause_q));

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int SYNC_STG  = 2,
    parameter int EXP_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic              pin_sense,
    input  logic              wdt_fault,
    input  logic              brown_ok,
    output logic              core_rst,
    output logic              dbg_rst,
    output logic              periph_rst,
    output logic              pin_pull_low,
    output logic              irq
);
    logic     pin_level, pin_fall;
    logic     brown_level_unused, brown_fall;
    logic     ctrl_go, busy, start, active, expire;
    rst_sel_t ctrl_bits, sel_q;
    mode_t    mode_q;
    cause_e   cause_q;

    rstctl_sync_edge #(.STAGES(SYNC_STG), .RESET_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_sense),
        .level(pin_level), .fall(pin_fall));

    rstctl_sync_edge #(.STAGES(SYNC_STG), .RESET_VAL(1'b1)) u_brown_sync (
        .clk(clk), .rst_n(rst_n), .async_in(brown_ok),
        .level(brown_level_unused), .fall(brown_fall));

    rstctl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .user_fall(pin_fall),
        .brown_fall(brown_fall), .pin_level(pin_level), .busy(busy),
        .rst_type(cause_q), .bus_rdata(bus_rdata), .mode_q(mode_q),
        .ctrl_go(ctrl_go), .ctrl_bits(ctrl_bits), .irq(irq));

    rstctl_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sw_go(ctrl_go), .sw_bits(ctrl_bits),
        .user_go(pin_fall & mode_q.ursten), .brown_go(brown_fall),
        .wdog_go(wdt_fault), .expire(expire), .busy(busy), .start(start),
        .active(active), .sel_q(sel_q), .cause_q(cause_q));

    rstctl_pulse_timer #(.EXP_W(EXP_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(start), .run(active),
        .tick(slow_tick), .erstl(mode_q.erstl), .expire(expire));

    assign core_rst     = active & sel_q.core;
    assign dbg_rst      = active & sel_q.dbg;
    assign periph_rst   = active & sel_q.periph;
    assign pin_pull_low = active & sel_q.ext;

    // R2: no reset output without a running sequence
    p_outputs_need_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst | dbg_rst | periph_rst | pin_pull_low) |-> busy);

endmodule

// File: tb/rstctl_top_test.sv
module rstctl_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        ext_level = 1'b1;
    logic        pin_sense;
    logic        wdt_fault = 1'b0;
    logic        brown_ok = 1'b1;
    logic        core_rst, dbg_rst, periph_rst, pin_pull_low, irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [31:0] q_exp[$];
    logic [31:0] q_mask[$];
    string       q_tag[$];
    logic        rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pin_sense = ext_level & ~pin_pull_low;

    rstctl_top uut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .pin_sense(pin_sense), .wdt_fault(wdt_fault),
        .brown_ok(brown_ok), .core_rst(core_rst), .dbg_rst(dbg_rst),
        .periph_rst(periph_rst), .pin_pull_low(pin_pull_low), .irq(irq));

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<100000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Scoreboard monitor
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen && q_exp.size() > 0) begin
            logic [31:0] e, m;
            string t;
            e = q_exp.pop_front();
            m = q_mask.pop_front();
            t = q_tag.pop_front();
            checks = checks + 1;
            if ((bus_rdata & m) !== (e & m)) begin
                fails = fails + 1;
                $display("FAIL %s: read actual=%h expected=%h mask=%h", t, bus_rdata, e, m);
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e,
                      input logic [31:0] m, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        q_exp.push_back(e); q_mask.push_back(m); q_tag.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    localparam logic [31:0] ALL = 32'hFFFF_FFFF;

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(4);
        // Reset state
        chk(core_rst | dbg_rst | periph_rst | pin_pull_low, 1'b0, "R2 reset outputs");
        chk(irq, 1'b0, "R7 reset irq");
        rd(4'h4, 32'h0001_0000, ALL, "R4 R8 status after reset");
        rd(4'h8, 32'h0, ALL, "R11 mode after reset");

        // Wrong key on mode
        wr(4'h8, 32'h5A01_0011);
        rd(4'h8, 32'h0, ALL, "R1 mode bad key");
        // E=0, user irq enable, brown irq enable
        wr(4'h8, 32'hA501_0010);
        rd(4'h8, 32'h0001_0010, ALL, "R11 mode readback");

        // Wrong key on command
        wr(4'h0, 32'h0000_0001);
        chk(core_rst, 1'b0, "R1 command bad key");
        rd(4'h4, 32'h0, 32'h0002_0000, "R1 not busy after bad key");

        // Software reset: core, periph, pin
        wr(4'h0, 32'hA500_000D);
        chk(core_rst, 1'b1, "R2 core asserted");
        chk(dbg_rst, 1'b0, "R2 debug not selected");
        chk(periph_rst, 1'b1, "R2 periph asserted");
        chk(pin_pull_low, 1'b1, "R2 pin pulled");
        rd(4'h4, 32'h0002_0000, 32'h0002_0000, "R5 busy during pulse");
        wr(4'h0, 32'hA500_0002);
        chk(dbg_rst, 1'b0, "R5 command ignored while busy");
        tick();
        chk(core_rst, 1'b1, "R6 still asserted after 1 of 2 ticks");
        tick();
        chk(core_rst, 1'b0, "R6 released after 2 ticks");
        chk(dbg_rst, 1'b0, "R5 dropped command not queued");
        idle(4);
        chk(irq, 1'b1, "R7 user flag with enable");
        rd(4'h4, 32'h0001_0301, ALL, "R3 R8 status after software reset");
        chk(irq, 1'b0, "R7 irq clear after read");
        rd(4'h4, 32'h0001_0300, ALL, "R3 flag cleared by read");

        // Brown-out
        @(negedge clk); brown_ok = 1'b0;
        idle(4);
        chk(core_rst, 1'b1, "R10 brown-out core reset");
        chk(periph_rst, 1'b1, "R10 brown-out periph reset");
        chk(pin_pull_low, 1'b0, "R10 brown-out no pin pull");
        chk(irq, 1'b1, "R7 brown flag with enable");
        tick(); tick();
        brown_ok = 1'b1;
        idle(3);
        rd(4'h4, 32'h0001_0502, ALL, "R10 R3 status after brown-out");

        // Debug-only command leaves cause unchanged
        wr(4'h0, 32'hA500_0002);
        chk(dbg_rst, 1'b1, "R2 debug reset");
        chk(core_rst, 1'b0, "R2 core not selected");
        tick(); tick();
        idle(2);
        rd(4'h4, 32'h0001_0500, ALL, "R8 cause kept without core bit");

        // User reset, E=2 gives 8 ticks
        wr(4'h8, 32'hA500_0201);
        @(negedge clk); ext_level = 1'b0;
        idle(4);
        chk(core_rst, 1'b1, "R9 user reset core");
        chk(periph_rst, 1'b1, "R9 user reset periph");
        ext_level = 1'b1;
        for (int i = 0; i < 7; i++) tick();
        chk(core_rst, 1'b1, "R6 asserted after 7 of 8 ticks");
        tick();
        chk(core_rst, 1'b0, "R6 released after 8 ticks");
        idle(3);
        chk(irq, 1'b0, "R7 flag masked without enable");
        rd(4'h4, 32'h0001_0401, ALL, "R9 status after user reset");

        // Watchdog and software in the same cycle
        @(negedge clk);
        wdt_fault = 1'b1; bus_addr = 4'h0; bus_wdata = 32'hA500_0002; bus_wr = 1'b1;
        @(negedge clk);
        wdt_fault = 1'b0; bus_wr = 1'b0;
        chk(core_rst, 1'b1, "R10 watchdog wins core");
        chk(dbg_rst, 1'b0, "R10 software request dropped");
        for (int i = 0; i < 8; i++) tick();
        idle(2);
        rd(4'h4, 32'h0001_0200, ALL, "R10 R8 watchdog cause");

        // User reset disabled
        wr(4'h8, 32'hA500_0000);
        @(negedge clk); ext_level = 1'b0;
        idle(6);
        chk(core_rst, 1'b0, "R9 no reset without enable");
        rd(4'h4, 32'h0000_0201, ALL, "R9 R4 flag and low pin level");
        ext_level = 1'b1;
        idle(4);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule